// File: doc/BRIEF.md
# Banked Internal Scratch RAM with Stack and Bit Access

This block holds the 128-byte on-chip working store of a small 8-bit controller core. One command port carries one operation per clock cycle. An operation can read or write a byte by direct address. It can also reach one of eight working registers through a two-bit bank select, read, set or clear a single bit by bit address, or push and pop bytes through a hardware stack pointer.

Byte addresses from 80h upward are not held here. A read or write to that range leaves the block on a strobed special-register bus, so that the neighbouring register file can serve it. All results appear on registered outputs in the cycle after the command. The bit-addressable window 20h–2Fh is held in flip-flops. Every other byte sits in an inferable synchronous RAM.

Top module: `iram_bank_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `sp_o` is 07h and `rvalid_o`, `bvalid_o`, `sfr_rd_o` and `sfr_wr_o` are all low.
- R2: A byte write (op 2) to an address below 80h stores `wdata_i`. A byte read (op 1) below 80h returns that byte on `rdata_o` with `rvalid_o` high in the cycle after the command.
- R3: Working-register access with index n (`addr_i[2:0]`) and bank b (`bank_i`) reaches byte 8·b + n. Op 3 reads it and op 4 writes it. The same byte is visible through direct byte access, and the banks do not share storage.
- R4: Bit address n below 80h selects byte 20h + (n >> 3), bit (n & 7). Bit set (op 6) and bit clear (op 7) change only that bit of the byte.
- R5: A bit read (op 5) below 80h returns the selected bit on `bit_o` with `bvalid_o` high in the cycle after the command.
- R6: Bit operations with a bit address of 80h or above change no stored byte and raise neither `bvalid_o` nor any special-register strobe.
- R7: A byte read or write at 80h or above stores nothing in this block. It pulses `sfr_rd_o` or `sfr_wr_o` for one cycle, carrying `addr_i[6:0]` on `sfr_addr_o` and `wdata_i` on `sfr_wdata_o`, and `rvalid_o` stays low.
- R8: A push (op 8) first increments the stack pointer and then stores `wdata_i` at the new pointer value. The first push after reset therefore lands at 08h.
- R9: A pop (op 9) returns the byte at the current stack pointer with `rvalid_o` high, then decrements the pointer, so pushes and pops are last-in first-out.
- R10: The stack pointer stays within 00h–7Fh. It wraps from 7Fh to 00h on push and from 00h to 7Fh on pop.
- R11: Op codes are 0 none, 1 byte read, 2 byte write, 3 register read, 4 register write, 5 bit read, 6 bit set, 7 bit clear, 8 push, 9 pop. Codes 10–15 behave as op 0. At most one of `rvalid_o`, `bvalid_o`, `sfr_rd_o` and `sfr_wr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code, one per cycle |
| bank_i | input | 2 | Working-register bank select |
| addr_i | input | 8 | Byte address, bit address or register index |
| wdata_i | input | 8 | Data for byte write, register write and push |
| rdata_o | output | 8 | Read data, meaningful when rvalid_o is high |
| rvalid_o | output | 1 | Byte, register or pop result valid |
| bit_o | output | 1 | Bit read result, meaningful when bvalid_o is high |
| bvalid_o | output | 1 | Bit read result valid |
| sp_o | output | 8 | Current stack pointer |
| sfr_rd_o | output | 1 | Special-register read strobe |
| sfr_wr_o | output | 1 | Special-register write strobe |
| sfr_addr_o | output | 7 | Special-register offset above 80h |
| sfr_wdata_o | output | 8 | Special-register write data |

## Verification
The properties assume that `op_i` and the other command inputs are steady around each rising edge and that exactly one operation is offered per cycle. They also assume that the op code is held at zero while reset is high, so that no push or pop is counted against the first cycle after reset. The bench drives every input on the falling edge and holds op 0 throughout reset. It writes each RAM byte before it reads it, because RAM contents are undefined after reset. Pops that only move the pointer around the wrap are checked on `sp_o` alone.

// File: rtl/iram_pkg.sv
package iram_pkg;

  // Operation codes on the command port
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_RD   = 4'd1,
    OP_WR   = 4'd2,
    OP_RREG = 4'd3,
    OP_WREG = 4'd4,
    OP_BRD  = 4'd5,
    OP_BSET = 4'd6,
    OP_BCLR = 4'd7,
    OP_PUSH = 4'd8,
    OP_POP  = 4'd9
  } iram_op_e;

  localparam int unsigned IRAM_AW      = 7;
  localparam int unsigned IRAM_DW      = 8;
  localparam int unsigned IRAM_BANK_W  = 2;
  localparam int unsigned IRAM_REG_W   = 3;
  localparam int unsigned IRAM_BIT_BASE = 32'h20;
  localparam int unsigned IRAM_SP_INIT  = 32'h07;

endpackage

// File: rtl/iram_decode.sv
module iram_decode
  import iram_pkg::*;
#(
  parameter int unsigned AW       = IRAM_AW,
  parameter int unsigned DW       = IRAM_DW,
  parameter int unsigned BANK_W   = IRAM_BANK_W,
  parameter int unsigned REG_W    = IRAM_REG_W,
  parameter int unsigned BIT_BASE = IRAM_BIT_BASE,
  localparam int unsigned BI_W    = $clog2(DW),
  localparam int unsigned NB_LOG2 = AW - BI_W
) (
  input  iram_op_e              op,
  input  logic [AW:0]           addr,
  input  logic [BANK_W-1:0]     bank,
  input  logic [AW-1:0]         sp,
  output logic [AW-1:0]         ea,
  output logic                  in_bits,
  output logic [BI_W-1:0]       bit_idx,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  bit_rd,
  output logic                  bit_wr,
  output logic                  bit_val,
  output logic                  sfr_rd,
  output logic                  sfr_wr,
  output logic                  push,
  output logic                  pop
);

  localparam logic [AW-1:0] BASE_V = AW'(BIT_BASE);
  localparam logic [AW-1:0] ONE_V  = AW'(1);

  logic [AW-1:0] bit_byte;
  logic          high;

  assign high     = addr[AW];
  assign bit_byte = BASE_V + AW'(addr[AW-1:BI_W]);
  assign bit_idx  = addr[BI_W-1:0];
  // Region is aligned to its own size
  assign in_bits  = (ea >> NB_LOG2) == (BASE_V >> NB_LOG2);

  always_comb begin
    ea      = addr[AW-1:0];
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    bit_rd  = 1'b0;
    bit_wr  = 1'b0;
    bit_val = 1'b0;
    sfr_rd  = 1'b0;
    sfr_wr  = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    unique case (op)
      OP_RD: begin
        sfr_rd = high;
        mem_rd = !high;
      end
      OP_WR: begin
        sfr_wr = high;
        mem_wr = !high;
      end
      OP_RREG, OP_WREG: begin
        ea = '0;
        ea[BANK_W+REG_W-1:0] = {bank, addr[REG_W-1:0]};
        mem_rd = (op == OP_RREG);
        mem_wr = (op == OP_WREG);
      end
      OP_BRD: begin
        ea     = bit_byte;
        bit_rd = !high;
      end
      OP_BSET, OP_BCLR: begin
        ea      = bit_byte;
        bit_wr  = !high;
        bit_val = (op == OP_BSET);
      end
      OP_PUSH: begin
        ea     = sp + ONE_V;
        mem_wr = 1'b1;
        push   = 1'b1;
      end
      OP_POP: begin
        ea     = sp;
        mem_rd = 1'b1;
        pop    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/iram_ram.sv
module iram_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // Single-port synchronous RAM, no reset on contents
  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    if (re) q <= mem[a];
  end

endmodule

// File: rtl/iram_bitreg.sv
module iram_bitreg #(
  parameter int unsigned DW      = 8,
  parameter int unsigned NB_LOG2 = 4,
  localparam int unsigned NB     = 1 << NB_LOG2,
  localparam int unsigned BI_W   = $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_we,
  input  logic               bit_we,
  input  logic               bit_val,
  input  logic               rd_en,
  input  logic [NB_LOG2-1:0] idx,
  input  logic [BI_W-1:0]    bsel,
  input  logic [DW-1:0]      wd,
  output logic [DW-1:0]      q
);

  logic [DW-1:0] regs [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic hit;
    assign hit = (idx == NB_LOG2'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (hit && byte_we) begin
        regs[g] <= wd;
      end else if (hit && bit_we) begin
        regs[g][bsel] <= bit_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (rd_en) q <= regs[idx];
  end

endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
  parameter int unsigned AW      = 7,
  parameter int unsigned SP_INIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp
);

  always_ff @(posedge clk) begin
    if (rst)       sp <= AW'(SP_INIT);
    else if (push) sp <= sp + AW'(1);
    else if (pop)  sp <= sp - AW'(1);
  end

endmodule

// File: rtl/iram_bank_core.sv
module iram_bank_core
  import iram_pkg::*;
#(
  parameter int unsigned AW       = IRAM_AW,
  parameter int unsigned DW       = IRAM_DW,
  parameter int unsigned BANK_W   = IRAM_BANK_W,
  parameter int unsigned REG_W    = IRAM_REG_W,
  parameter int unsigned BIT_BASE = IRAM_BIT_BASE,
  parameter int unsigned SP_INIT  = IRAM_SP_INIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [AW:0]       addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              bit_o,
  output logic              bvalid_o,
  output logic [AW:0]       sp_o,
  output logic              sfr_rd_o,
  output logic              sfr_wr_o,
  output logic [AW-1:0]     sfr_addr_o,
  output logic [DW-1:0]     sfr_wdata_o
);

  localparam int unsigned BI_W    = $clog2(DW);
  localparam int unsigned NB_LOG2 = AW - BI_W;

  logic [AW-1:0]   ea, sp;
  logic [BI_W-1:0] bit_idx;
  logic in_bits, mem_rd, mem_wr, bit_rd, bit_wr, bit_val;
  logic sfr_rd, sfr_wr, push, pop;
  logic [DW-1:0] ram_q, bits_q;

  iram_decode #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_dec (
    .op      (iram_op_e'(op_i)),
    .addr    (addr_i),
    .bank    (bank_i),
    .sp      (sp),
    .ea      (ea),
    .in_bits (in_bits),
    .bit_idx (bit_idx),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .bit_rd  (bit_rd),
    .bit_wr  (bit_wr),
    .bit_val (bit_val),
    .sfr_rd  (sfr_rd),
    .sfr_wr  (sfr_wr),
    .push    (push),
    .pop     (pop)
  );

  iram_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk (clk),
    .we  (mem_wr && !in_bits),
    .re  (mem_rd && !in_bits),
    .a   (ea),
    .wd  (wdata_i),
    .q   (ram_q)
  );

  iram_bitreg #(.DW(DW), .NB_LOG2(NB_LOG2)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .byte_we (mem_wr && in_bits),
    .bit_we  (bit_wr),
    .bit_val (bit_val),
    .rd_en   ((mem_rd || bit_rd) && in_bits),
    .idx     (ea[NB_LOG2-1:0]),
    .bsel    (bit_idx),
    .wd      (wdata_i),
    .q       (bits_q)
  );

  iram_sp #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .sp   (sp)
  );

  logic            src_bits_q;
  logic [BI_W-1:0] bsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o    <= 1'b0;
      bvalid_o    <= 1'b0;
      sfr_rd_o    <= 1'b0;
      sfr_wr_o    <= 1'b0;
      sfr_addr_o  <= '0;
      sfr_wdata_o <= '0;
      src_bits_q  <= 1'b0;
      bsel_q      <= '0;
    end else begin
      rvalid_o    <= mem_rd;
      bvalid_o    <= bit_rd;
      sfr_rd_o    <= sfr_rd;
      sfr_wr_o    <= sfr_wr;
      src_bits_q  <= in_bits;
      bsel_q      <= bit_idx;
      if (sfr_rd || sfr_wr) begin
        sfr_addr_o  <= addr_i[AW-1:0];
        sfr_wdata_o <= wdata_i;
      end
    end
  end

  assign rdata_o = src_bits_q ? bits_q : ram_q;
  assign bit_o   = bits_q[bsel_q];
  assign sp_o    = {1'b0, sp};

endmodule

// File: rtl/iram_checker.sv
module iram_checker #(
  parameter int unsigned AW      = 7,
  parameter int unsigned SP_INIT = 7
) (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op_i,
  input logic [AW:0] addr_i,
  input logic        rvalid_o,
  input logic        bvalid_o,
  input logic [AW:0] sp_o,
  input logic        sfr_rd_o,
  input logic        sfr_wr_o
);

  logic is_bitop;
  assign is_bitop = (op_i == 4'd5) || (op_i == 4'd6) || (op_i == 4'd7);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp_o == (AW+1)'(SP_INIT)) && !rvalid_o && !bvalid_o && !sfr_rd_o && !sfr_wr_o);

  assert_low_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd1 && !addr_i[AW]) |=> rvalid_o);

  assert_bit_high_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (is_bitop && addr_i[AW]) |=> !bvalid_o && !sfr_rd_o && !sfr_wr_o);

  assert_sfr_read_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd1 && addr_i[AW]) |=> sfr_rd_o && !rvalid_o);

  assert_sfr_write_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2 && addr_i[AW]) |=> sfr_wr_o && !rvalid_o);

  assert_push_incr_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd8) |=> sp_o[AW-1:0] == AW'($past(sp_o[AW-1:0]) + AW'(1)));

  assert_sp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i != 4'd8 && op_i != 4'd9) |=> $stable(sp_o));

  assert_pop_decr_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9) |=> sp_o[AW-1:0] == AW'($past(sp_o[AW-1:0]) - AW'(1)) && rvalid_o);

  assert_sp_range_R10: assert property (@(posedge clk) disable iff (rst)
    !sp_o[AW]);

  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rvalid_o, bvalid_o, sfr_rd_o, sfr_wr_o}));

endmodule

bind iram_bank_core iram_checker #(.AW(AW), .SP_INIT(SP_INIT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .bvalid_o (bvalid_o),
  .sp_o     (sp_o),
  .sfr_rd_o (sfr_rd_o),
  .sfr_wr_o (sfr_wr_o)
);

// File: tb/sim_iram_bank_core.sv
module sim_iram_bank_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [1:0] bank_i = 2'd0;
  logic [7:0] addr_i = 8'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o, sp_o, sfr_wdata_o;
  logic [6:0] sfr_addr_o;
  logic       rvalid_o, bit_o, bvalid_o, sfr_rd_o, sfr_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iram_bank_core u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .bank_i(bank_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .bit_o(bit_o),
    .bvalid_o(bvalid_o), .sp_o(sp_o), .sfr_rd_o(sfr_rd_o), .sfr_wr_o(sfr_wr_o),
    .sfr_addr_o(sfr_addr_o), .sfr_wdata_o(sfr_wdata_o)
  );

  // {req[3:0], kind[1:0], op[3:0], bank[1:0], addr[7:0], wdata[7:0], expect[7:0]}
  // kind: 0 no check, 1 rdata with rvalid, 2 bit with bvalid, 3 bvalid low
  localparam int NV = 24;
  localparam logic [35:0] VEC [NV] = '{
    {4'd2, 2'd0, 4'd2, 2'd0, 8'h05, 8'hA5, 8'h00},  // R2 write 05h
    {4'd2, 2'd1, 4'd1, 2'd0, 8'h05, 8'h00, 8'hA5},  // R2 read 05h
    {4'd3, 2'd0, 4'd4, 2'd2, 8'h03, 8'h3C, 8'h00},  // R3 bank 2 reg 3 -> 13h
    {4'd3, 2'd1, 4'd1, 2'd0, 8'h13, 8'h00, 8'h3C},  // R3 direct view of 13h
    {4'd3, 2'd1, 4'd3, 2'd2, 8'h03, 8'h00, 8'h3C},  // R3 register read back
    {4'd3, 2'd0, 4'd4, 2'd0, 8'h03, 8'h11, 8'h00},  // R3 bank 0 reg 3 -> 03h
    {4'd3, 2'd1, 4'd3, 2'd2, 8'h03, 8'h00, 8'h3C},  // R3 bank 2 untouched
    {4'd3, 2'd1, 4'd1, 2'd0, 8'h03, 8'h00, 8'h11},  // R3 direct view of 03h
    {4'd3, 2'd0, 4'd4, 2'd3, 8'h07, 8'hE7, 8'h00},  // R3 bank 3 reg 7 -> 1Fh
    {4'd3, 2'd1, 4'd1, 2'd0, 8'h1F, 8'h00, 8'hE7},  // R3 direct view of 1Fh
    {4'd4, 2'd0, 4'd2, 2'd0, 8'h24, 8'h00, 8'h00},  // R4 clear 24h
    {4'd4, 2'd0, 4'd6, 2'd0, 8'h22, 8'h00, 8'h00},  // R4 set bit 22h -> 24h.2
    {4'd4, 2'd1, 4'd1, 2'd0, 8'h24, 8'h00, 8'h04},  // R4 byte shows one bit
    {4'd5, 2'd2, 4'd5, 2'd0, 8'h22, 8'h00, 8'h01},  // R5 bit 22h is 1
    {4'd5, 2'd2, 4'd5, 2'd0, 8'h23, 8'h00, 8'h00},  // R5 bit 23h is 0
    {4'd4, 2'd0, 4'd2, 2'd0, 8'h2F, 8'hFF, 8'h00},  // R4 fill 2Fh
    {4'd4, 2'd0, 4'd7, 2'd0, 8'h7F, 8'h00, 8'h00},  // R4 clear bit 7Fh -> 2Fh.7
    {4'd4, 2'd1, 4'd1, 2'd0, 8'h2F, 8'h00, 8'h7F},  // R4 other bits kept
    {4'd5, 2'd2, 4'd5, 2'd0, 8'h7E, 8'h00, 8'h01},  // R5 bit 7Eh is 1
    {4'd6, 2'd0, 4'd6, 2'd0, 8'hA2, 8'h00, 8'h00},  // R6 high bit set ignored
    {4'd6, 2'd3, 4'd5, 2'd0, 8'hA2, 8'h00, 8'h00},  // R6 high bit read no valid
    {4'd6, 2'd1, 4'd1, 2'd0, 8'h24, 8'h00, 8'h04},  // R6 24h unchanged
    {4'd2, 2'd0, 4'd2, 2'd0, 8'h7F, 8'h5A, 8'h00},  // R2 top byte
    {4'd2, 2'd1, 4'd1, 2'd0, 8'h7F, 8'h00, 8'h5A}   // R2 top byte read
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] bank, logic [7:0] addr, logic [7:0] wd);
    op_i = op; bank_i = bank; addr_i = addr; wdata_i = wd;
    @(negedge clk);
    op_i = 4'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is still high
    check("R1 sp in reset", sp_o, 8'h07);
    check("R1 flags in reset", {4'd0, rvalid_o, bvalid_o, sfr_rd_o, sfr_wr_o}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sp after reset", sp_o, 8'h07);
    check("R1 flags after reset", {4'd0, rvalid_o, bvalid_o, sfr_rd_o, sfr_wr_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[35:32], i);
      issue(v[29:26], v[25:24], v[23:16], v[15:8]);
      case (v[31:30])
        2'd1: begin
          check({tag, " rvalid"}, {7'd0, rvalid_o}, 8'h01);
          check({tag, " rdata"}, rdata_o, v[7:0]);
        end
        2'd2: begin
          check({tag, " bvalid"}, {7'd0, bvalid_o}, 8'h01);
          check({tag, " bit"}, {7'd0, bit_o}, v[7:0]);
        end
        2'd3: check({tag, " no bvalid"}, {7'd0, bvalid_o, sfr_rd_o, sfr_wr_o}, 8'h00);
        default: ;
      endcase
    end

    // R7 special-register write leaves RAM alone
    issue(4'd2, 2'd0, 8'h85, 8'h99);
    check("R7 sfr_wr strobe", {sfr_wr_o, sfr_rd_o, rvalid_o}, 3'b100);
    check("R7 sfr addr", {1'b0, sfr_addr_o}, 8'h05);
    check("R7 sfr wdata", sfr_wdata_o, 8'h99);
    @(negedge clk);
    check("R7 strobe one cycle", {7'd0, sfr_wr_o}, 8'h00);
    issue(4'd1, 2'd0, 8'h05, 8'h00);
    check("R7 byte 05h unchanged", rdata_o, 8'hA5);
    issue(4'd1, 2'd0, 8'h90, 8'h00);
    check("R7 sfr_rd strobe", {sfr_rd_o, sfr_wr_o, rvalid_o}, 3'b100);
    check("R7 sfr read addr", {1'b0, sfr_addr_o}, 8'h10);

    // R11 unused op code does nothing
    issue(4'd12, 2'd0, 8'h05, 8'h00);
    check("R11 unused op", {4'd0, rvalid_o, bvalid_o, sfr_rd_o, sfr_wr_o}, 8'h00);
    check("R11 sp untouched", sp_o, 8'h07);

    // R8 push pre-increments
    issue(4'd8, 2'd0, 8'h00, 8'h11);
    check("R8 sp after push", sp_o, 8'h08);
    issue(4'd1, 2'd0, 8'h08, 8'h00);
    check("R8 first push at 08h", rdata_o, 8'h11);
    issue(4'd8, 2'd0, 8'h00, 8'h22);
    check("R8 sp after second push", sp_o, 8'h09);
    // R9 pop order
    issue(4'd9, 2'd0, 8'h00, 8'h00);
    check("R9 pop valid", {7'd0, rvalid_o}, 8'h01);
    check("R9 pop last in", rdata_o, 8'h22);
    check("R9 sp after pop", sp_o, 8'h08);
    issue(4'd9, 2'd0, 8'h00, 8'h00);
    check("R9 pop first in", rdata_o, 8'h11);
    check("R9 sp back to init", sp_o, 8'h07);

    // R10 wrap at both ends
    for (int k = 0; k < 7; k++) issue(4'd9, 2'd0, 8'h00, 8'h00);
    check("R10 sp at bottom", sp_o, 8'h00);
    issue(4'd9, 2'd0, 8'h00, 8'h00);
    check("R10 pop wraps", sp_o, 8'h7F);
    issue(4'd8, 2'd0, 8'h00, 8'h77);
    check("R10 push wraps", sp_o, 8'h00);
    issue(4'd1, 2'd0, 8'h00, 8'h00);
    check("R10 wrapped push stored at 00h", rdata_o, 8'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule